// File: doc/BRIEF.md
# Three-Track Phase-Encoded Tape Codec

This block records and recovers three parallel data tracks on tape. A prerecorded timing track sets the clock for the data tracks. Timing-track zero crossings reach the block as two single-cycle pulses. `tp0Pulse` marks a rising crossing and `tp1Pulse` marks a falling crossing.

In write mode, three per-track buffers set the write-current polarity of their tracks directly. On each `tp0Pulse` the buffers take the next 3-bit group, which arrives earlier through a ready/valid handshake. On each `tp1Pulse` the buffers invert. Every bit cell therefore ends with a polarity reversal. In read mode, the same buffers sample the data-amplifier polarities on `tp1Pulse` only, and the block presents them with a one-cycle valid strobe.

The mark channel is sampled on every falling timing crossing in either mode. The block also watches that the two timing pulses strictly alternate. It keeps sticky error flags for a broken alternation and for a write-data underrun.

Top module: `tape_track_codec`

## Requirements
- R1: After reset, `writeCurrent`, `rdData`, `rdValid`, `markBit`, `markValid`, `underrunErr` and `timingErr` are all 0, and `wrReady` is 1.
- R2: In write mode (`writeMode`=1), a `tp0Pulse` loads the held group into the buffers. Bit i of the group drives track i. `writeCurrent` shows the group from the cycle after the pulse.
- R3: In write mode, a `tp1Pulse` inverts all track buffers, whatever their values. `writeCurrent` shows the inverted value from the cycle after the pulse.
- R4: In read mode (`writeMode`=0), a `tp1Pulse` copies `rdPolarity` into the buffers. From the next cycle `rdData` holds the copied value and `rdValid` is 1 for exactly one cycle. `writeCurrent` stays 0 in read mode.
- R5: A `tp1Pulse` in write mode never raises `rdValid`.
- R6: `wrReady` is 1 exactly when the one-group holding register is empty. A transfer (`wrValid` and `wrReady`) fills it. A write-mode `tp0Pulse` that loads the group empties it again.
- R7: A write-mode `tp0Pulse` with an empty holding register loads the last group again (0 if no group has been loaded yet) and sets `underrunErr`. The flag stays set until reset.
- R8: `timingErr` is set when a `tp0Pulse` follows a `tp0Pulse`, or a `tp1Pulse` follows a `tp1Pulse`, with no pulse of the other kind between them. It is also set when both pulses arrive in the same cycle. The flag stays set until reset. Strict alternation never sets it.
- R9: On every `tp1Pulse`, in either mode, `markIn` is captured into `markBit`, and `markValid` is 1 for the following cycle only.
- R10: In read mode, a `tp0Pulse` leaves the buffers (`rdData`) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| writeMode | input | 1 | 1 selects write mode, 0 selects read mode |
| tp0Pulse | input | 1 | Rising timing-track crossing, single-cycle pulse |
| tp1Pulse | input | 1 | Falling timing-track crossing, single-cycle pulse |
| wrData | input | TRACKS | Next write group, bit i for track i |
| wrValid | input | 1 | `wrData` is offered |
| wrReady | output | 1 | Holding register can take a group |
| writeCurrent | output | TRACKS | Write-current polarity per track |
| rdPolarity | input | TRACKS | Data-amplifier polarity per track |
| rdData | output | TRACKS | Track buffers, read result |
| rdValid | output | 1 | One-cycle strobe after a read sample |
| markIn | input | 1 | Mark-channel polarity |
| markBit | output | 1 | Last sampled mark value |
| markValid | output | 1 | One-cycle strobe after a mark sample |
| underrunErr | output | 1 | Sticky write-underrun flag |
| timingErr | output | 1 | Sticky timing-alternation flag |

## Verification
The bench uses the default `TRACKS`=3. With three tracks, the chosen groups can mix set and clear bits (101, 011, 110) and also cover all-zero and all-one values. This makes a per-track swap, a missed inversion on one track, or a track tied to a neighbour show up at the ports. Three tracks also keep every expected value small enough to compute by hand in each directed task.

// File: rtl/tape_codec_pkg.sv
package tape_codec_pkg;

  // Strobes sent from control to datapath, one per datapath action.
  typedef struct packed {
    logic accept;      // holding register takes wrData
    logic loadNew;     // buffers take the held group
    logic loadRepeat;  // buffers take the last group again (underrun)
    logic complement;  // buffers invert
    logic sampleRead;  // buffers take the read polarities
    logic markSample;  // mark channel captured
  } codecStrobes_t;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_TP0  = 2'd1,
    PH_TP1  = 2'd2
  } tapePhase_t;

endpackage

// File: rtl/tape_codec_ctrl.sv
module tape_codec_ctrl
  import tape_codec_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          writeMode,
  input  logic          tp0Pulse,
  input  logic          tp1Pulse,
  input  logic          wrValid,
  output logic          wrReady,
  output codecStrobes_t strobes,
  output logic          rdValid,
  output logic          markValid,
  output logic          underrunErr,
  output logic          timingErr
);

  logic       haveGroup;
  tapePhase_t lastPhase;
  logic       phaseFault;

  assign wrReady = !haveGroup;

  always_comb begin
    strobes            = '0;
    strobes.accept     = wrValid && !haveGroup;
    strobes.loadNew    = writeMode && tp0Pulse && haveGroup;
    strobes.loadRepeat = writeMode && tp0Pulse && !haveGroup;
    strobes.complement = writeMode && tp1Pulse;
    strobes.sampleRead = !writeMode && tp1Pulse;
    strobes.markSample = tp1Pulse;
  end

  always_comb begin
    phaseFault = (tp0Pulse && tp1Pulse) ||
                 (tp0Pulse && lastPhase == PH_TP0) ||
                 (tp1Pulse && lastPhase == PH_TP1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveGroup   <= 1'b0;
      lastPhase   <= PH_NONE;
      rdValid     <= 1'b0;
      markValid   <= 1'b0;
      underrunErr <= 1'b0;
      timingErr   <= 1'b0;
    end else begin
      if (strobes.loadNew)     haveGroup <= 1'b0;
      else if (strobes.accept) haveGroup <= 1'b1;
      if (tp0Pulse && !tp1Pulse)      lastPhase <= PH_TP0;
      else if (tp1Pulse && !tp0Pulse) lastPhase <= PH_TP1;
      rdValid   <= strobes.sampleRead;
      markValid <= strobes.markSample;
      if (strobes.loadRepeat) underrunErr <= 1'b1;
      if (phaseFault)         timingErr   <= 1'b1;
    end
  end

  assert_timing_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    timingErr |=> timingErr);

  assert_double_tp0_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tp0Pulse && !tp1Pulse && lastPhase == PH_TP0) |=> timingErr);

  assert_underrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    underrunErr |=> underrunErr);

  assert_ready_after_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadNew |=> wrReady);

endmodule

// File: rtl/tape_codec_dp.sv
module tape_codec_dp
  import tape_codec_pkg::*;
#(
  parameter int TRACKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  codecStrobes_t     strobes,
  input  logic [TRACKS-1:0] wrData,
  input  logic [TRACKS-1:0] rdPolarity,
  input  logic              markIn,
  output logic [TRACKS-1:0] bufQ,
  output logic              markBit
);

  logic [TRACKS-1:0] holdQ;
  logic [TRACKS-1:0] lastQ;
  logic [TRACKS-1:0] bufNext;

  // A load comes first; a complement in the same cycle acts on the loaded group.
  always_comb begin
    bufNext = bufQ;
    if (strobes.loadNew)         bufNext = holdQ;
    else if (strobes.loadRepeat) bufNext = lastQ;
    if (strobes.complement)      bufNext = ~bufNext;
    if (strobes.sampleRead)      bufNext = rdPolarity;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ   <= '0;
      lastQ   <= '0;
      bufQ    <= '0;
      markBit <= 1'b0;
    end else begin
      if (strobes.accept)     holdQ   <= wrData;
      if (strobes.loadNew)    lastQ   <= holdQ;
      bufQ <= bufNext;
      if (strobes.markSample) markBit <= markIn;
    end
  end

  assert_complement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.complement && !strobes.loadNew && !strobes.loadRepeat)
      |=> bufQ == ~$past(bufQ));

  assert_read_sample_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sampleRead |=> bufQ == $past(rdPolarity));

  assert_mark_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.markSample |=> markBit == $past(markIn));

endmodule

// File: rtl/tape_track_codec.sv
module tape_track_codec
  import tape_codec_pkg::*;
#(
  parameter int TRACKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              writeMode,
  input  logic              tp0Pulse,
  input  logic              tp1Pulse,
  input  logic [TRACKS-1:0] wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [TRACKS-1:0] writeCurrent,
  input  logic [TRACKS-1:0] rdPolarity,
  output logic [TRACKS-1:0] rdData,
  output logic              rdValid,
  input  logic              markIn,
  output logic              markBit,
  output logic              markValid,
  output logic              underrunErr,
  output logic              timingErr
);

  codecStrobes_t     strobes;
  logic [TRACKS-1:0] bufQ;

  tape_codec_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .writeMode   (writeMode),
    .tp0Pulse    (tp0Pulse),
    .tp1Pulse    (tp1Pulse),
    .wrValid     (wrValid),
    .wrReady     (wrReady),
    .strobes     (strobes),
    .rdValid     (rdValid),
    .markValid   (markValid),
    .underrunErr (underrunErr),
    .timingErr   (timingErr)
  );

  tape_codec_dp #(.TRACKS(TRACKS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .rdPolarity (rdPolarity),
    .markIn     (markIn),
    .bufQ       (bufQ),
    .markBit    (markBit)
  );

  assign writeCurrent = writeMode ? bufQ : '0;
  assign rdData       = bufQ;

  assert_read_tp0_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!writeMode && !tp1Pulse) |=> $stable(rdData));

  assert_write_no_rdvalid_R5: assert property (@(posedge clk) disable iff (!rstN)
    (writeMode && tp1Pulse) |=> !rdValid);

endmodule

// File: tb/tape_track_codec_tb.sv
module tape_track_codec_tb;

  localparam int TRACKS = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              writeMode = 1'b1;
  logic              tp0Pulse = 1'b0;
  logic              tp1Pulse = 1'b0;
  logic [TRACKS-1:0] wrData = '0;
  logic              wrValid = 1'b0;
  logic              wrReady;
  logic [TRACKS-1:0] writeCurrent;
  logic [TRACKS-1:0] rdPolarity = '0;
  logic [TRACKS-1:0] rdData;
  logic              rdValid;
  logic              markIn = 1'b0;
  logic              markBit;
  logic              markValid;
  logic              underrunErr;
  logic              timingErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tape_track_codec #(.TRACKS(TRACKS)) u_dut (
    .clk(clk), .rstN(rstN), .writeMode(writeMode),
    .tp0Pulse(tp0Pulse), .tp1Pulse(tp1Pulse),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .writeCurrent(writeCurrent), .rdPolarity(rdPolarity), .rdData(rdData),
    .rdValid(rdValid), .markIn(markIn), .markBit(markBit),
    .markValid(markValid), .underrunErr(underrunErr), .timingErr(timingErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; writeMode = mode; tp0Pulse = 0; tp1Pulse = 0; wrValid = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulse0();
    tp0Pulse = 1'b1;
    @(negedge clk);
    tp0Pulse = 1'b0;
  endtask

  task automatic pulse1();
    tp1Pulse = 1'b1;
    @(negedge clk);
    tp1Pulse = 1'b0;
  endtask

  task automatic pushGroup(input logic [TRACKS-1:0] g);
    wrData = g; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic testReset();
    doReset(1'b1);
    check("R1 writeCurrent", writeCurrent, 0);
    check("R1 rdData", rdData, 0);
    check("R1 rdValid", rdValid, 0);
    check("R1 markBit", markBit, 0);
    check("R1 markValid", markValid, 0);
    check("R1 underrunErr", underrunErr, 0);
    check("R1 timingErr", timingErr, 0);
    check("R1 wrReady", wrReady, 1);
  endtask

  task automatic testWrite();
    logic [TRACKS-1:0] groups [3] = '{3'b101, 3'b011, 3'b000};
    doReset(1'b1);
    foreach (groups[i]) begin
      pushGroup(groups[i]);
      check("R6 ready low when held", wrReady, 0);
      pulse0();
      check("R2 load group", writeCurrent, groups[i]);
      check("R6 ready after load", wrReady, 1);
      pulse1();
      check("R3 complement", writeCurrent, 3'(~groups[i]));
      check("R5 no rdValid in write", rdValid, 0);
    end
    check("R8 clean alternation", timingErr, 0);
    check("R7 no underrun", underrunErr, 0);
  endtask

  task automatic testUnderrun();
    doReset(1'b1);
    pushGroup(3'b110);
    pulse0();
    pulse1();
    check("R7 no flag yet", underrunErr, 0);
    pulse0();
    check("R7 repeat last group", writeCurrent, 3'b110);
    check("R7 underrun flag", underrunErr, 1);
    pulse1();
    check("R3 complement after repeat", writeCurrent, 3'b001);
    check("R7 flag sticky", underrunErr, 1);
  endtask

  task automatic testRead();
    doReset(1'b0);
    rdPolarity = 3'b110; markIn = 1'b1;
    pulse0();
    check("R10 tp0 ignored in read", rdData, 0);
    check("R10 no rdValid on tp0", rdValid, 0);
    pulse1();
    check("R4 sample", rdData, 3'b110);
    check("R4 rdValid", rdValid, 1);
    check("R4 no current in read", writeCurrent, 0);
    check("R9 mark read mode", markBit, 1);
    check("R9 markValid", markValid, 1);
    rdPolarity = 3'b011;
    @(negedge clk);
    check("R4 rdValid one cycle", rdValid, 0);
    check("R9 markValid one cycle", markValid, 0);
    pulse0();
    check("R10 tp0 keeps data", rdData, 3'b110);
    pulse1();
    check("R4 second sample", rdData, 3'b011);
  endtask

  task automatic testMarkWrite();
    doReset(1'b1);
    markIn = 1'b1;
    pushGroup(3'b010);
    pulse0();
    check("R9 no mark on tp0", markValid, 0);
    pulse1();
    check("R9 mark write mode", markBit, 1);
    check("R9 markValid write", markValid, 1);
    markIn = 1'b0;
    pulse0();
    pulse1();
    check("R9 mark low", markBit, 0);
  endtask

  task automatic testTiming();
    doReset(1'b1);
    pulse0();
    pulse0();
    check("R8 double tp0", timingErr, 1);
    pulse1();
    check("R8 sticky", timingErr, 1);
    doReset(1'b0);
    pulse1();
    pulse1();
    check("R8 double tp1", timingErr, 1);
    doReset(1'b0);
    tp0Pulse = 1'b1; tp1Pulse = 1'b1;
    @(negedge clk);
    tp0Pulse = 1'b0; tp1Pulse = 1'b0;
    check("R8 simultaneous", timingErr, 1);
  endtask

  initial begin
    testReset();
    testWrite();
    testUnderrun();
    testRead();
    testMarkWrite();
    testTiming();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule